// File: doc/BRIEF.md
# Register-Adjacent Bus Window Sequencer

This block runs every CPU access to one 1 KB external address window. The window sits directly after a relocatable on-chip register block. After reset the register block starts at $0000, so the window covers $0400 to $07FF. When the register block base moves, the window moves with it.

Two control inputs shape accesses that fall inside the window:
- a narrow-path bit, which makes the window behave as an 8-bit-only bus on the upper byte lane;
- a stretch field, which adds up to three extra E-clock cycles to every bus cycle.

The operating mode decides whether each of these controls takes effect.

In narrow operation a 16-bit access becomes two byte cycles. The even byte goes first, and each byte cycle gets the full stretch. The CPU sees a one-cycle ready pulse only after the last bus cycle has finished, with read data already assembled into a word. The block has one clock, which is treated as the E clock, so each bus cycle lasts one clock.

The sequencer is a four-state machine:
- `S_IDLE` moves to `S_BEAT0` when a request is accepted. This transition is called *accept*.
- `S_BEAT0` is the first or only byte/word cycle. It stays in `S_BEAT0` while its stretch counter runs. It then moves to `S_BEAT1` when the access was split (*split*), or to `S_DONE` otherwise (*finish*).
- `S_BEAT1` is the second byte cycle. It stays in `S_BEAT1` while stretching, then moves to `S_DONE` (*finish*).
- `S_DONE` raises ready for one cycle and returns to `S_IDLE` (*retire*).

Top module: `bus_window_ctrl`

## Requirements
- R1: After reset `cpu_ready`, `bus_cyc`, `bus_we`, `bus_hi_en` and `bus_lo_en` are all low.
- R2: The window covers the addresses from `reg_base`+1024 to `reg_base`+2047. With `reg_base`=0 that is $0400 to $07FF. Changing `reg_base` moves the window, so the old range decodes as outside.
- R3: In expanded-wide mode (`mode`=01) and expanded-narrow mode (`mode`=10), every bus cycle of a window access lasts 1+S clocks, where S is the value of `ctl_stretch` (00→0, 01→1, 10→2, 11→3). This holds whatever the value of `ctl_narrow`.
- R4: In single-chip mode (00) and peripheral mode (11), and for any address outside the window, each bus cycle lasts exactly one clock.
- R5: In mode 01, a window access with `ctl_narrow`=1 drives only the upper lane (`bus_hi_en`=1, `bus_lo_en`=0). Byte data travels on `bus_wdata[15:8]` and `bus_rdata[15:8]`.
- R6: `ctl_narrow` has no effect in modes 00, 10 and 11. Mode 10 is always narrow, inside and outside the window. Modes 00 and 11 are always wide. Outside the window, mode 01 is wide.
- R7: A narrow word access (`cpu_word`=1) makes two byte cycles. The first is at the even address and carries the high byte. The second is at the odd address and carries the low byte. Each of the two cycles receives the full stretch.
- R8: `cpu_ready` is a single-cycle pulse. It appears in the clock after the last bus cycle. On a read, `cpu_rdata` holds the result in that cycle: for a word, {even byte, odd byte}; for a byte, the byte in bits 7:0 with zero above.
- R9: Wide lane mapping:
  - A word access enables both lanes, with the even byte on [15:8].
  - A byte access at an even address uses the upper lane.
  - A byte access at an odd address uses the lower lane.
  - Byte write data comes from `cpu_wdata[7:0]`.
  - Both lane enables and `bus_we` are low whenever `bus_cyc` is low.
- R10: Address, data, direction, size, mode, `reg_base` and both controls are sampled when the request is accepted. Changing them during the access does not alter that access.
- R11: A request raised while an access is in progress is ignored. No extra bus cycle follows the ready pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one E clock per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Access request, accepted in the idle state |
| cpu_addr | input | ADDR_W | CPU byte address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| cpu_wdata | input | 16 | Write data (byte in bits 7:0) |
| cpu_rdata | output | 16 | Read data, valid with `cpu_ready` |
| cpu_ready | output | 1 | One-cycle completion pulse |
| reg_base | input | ADDR_W | Base address of the register block |
| mode | input | 2 | 00 single-chip, 01 expanded-wide, 10 expanded-narrow, 11 peripheral |
| ctl_narrow | input | 1 | Window narrow-path select |
| ctl_stretch | input | STR_W | Window stretch count in E clocks |
| bus_addr | output | ADDR_W | External address |
| bus_cyc | output | 1 | High for every clock of a bus cycle |
| bus_we | output | 1 | External write strobe |
| bus_hi_en | output | 1 | Upper byte lane enable |
| bus_lo_en | output | 1 | Lower byte lane enable |
| bus_wdata | output | 16 | External write data, two byte lanes |
| bus_rdata | input | 16 | External read data, two byte lanes |

## Verification
The bench builds the block with its default parameters:
- `ADDR_W`=16;
- a 1024-byte register span and a 1024-byte window;
- `STR_W`=2.

These values put every stretch encoding from 0 to 3 within reach. With them the bench sweeps every combination of mode, stretch, narrow bit and access size, for both reads and writes. It also places the window at both the reset base and a relocated base. This covers the exact window edges and the split-word ordering under maximum stretch.

// File: rtl/bwc_pkg.sv
package bwc_pkg;

    typedef enum logic [1:0] {
        MD_SINGLE     = 2'b00,
        MD_EXP_WIDE   = 2'b01,
        MD_EXP_NARROW = 2'b10,
        MD_PERIPH     = 2'b11
    } bus_mode_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'b00,
        S_BEAT0 = 2'b01,
        S_BEAT1 = 2'b10,
        S_DONE  = 2'b11
    } seq_state_e;

    localparam int LANE_W = 8;
    localparam int DATA_W = 2 * LANE_W;

    function automatic logic mode_is_expanded(input bus_mode_e m);
        return (m == MD_EXP_WIDE) || (m == MD_EXP_NARROW);
    endfunction

endpackage

// File: rtl/bwc_window.sv
module bwc_window
    import bwc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int REG_SPAN = 1024,
    parameter int WIN_SIZE = 1024,
    parameter int STR_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] reg_base,
    input  logic [1:0]        mode,
    input  logic              ctl_narrow,
    input  logic [STR_W-1:0]  ctl_stretch,
    output logic              in_win,
    output logic              eff_narrow,
    output logic [STR_W-1:0]  eff_stretch
);

    localparam logic [ADDR_W-1:0] SPAN_OFS = ADDR_W'(REG_SPAN);
    localparam logic [ADDR_W-1:0] WIN_LIM  = ADDR_W'(WIN_SIZE);

    logic [ADDR_W-1:0] win_base;
    logic [ADDR_W-1:0] offset;
    bus_mode_e         md;

    always_comb begin
        md       = bus_mode_e'(mode);
        win_base = reg_base + SPAN_OFS;
        offset   = addr - win_base;
        in_win   = (offset < WIN_LIM);
    end

    // Stretch only in expanded modes, and only inside the window
    always_comb begin
        if (mode_is_expanded(md) && in_win) begin
            eff_stretch = ctl_stretch;
        end else begin
            eff_stretch = '0;
        end
    end

    // Width: the control bit counts only in expanded-wide mode inside the window
    always_comb begin
        unique case (md)
            MD_EXP_WIDE:   eff_narrow = in_win & ctl_narrow;
            MD_EXP_NARROW: eff_narrow = 1'b1;
            MD_SINGLE:     eff_narrow = 1'b0;
            MD_PERIPH:     eff_narrow = 1'b0;
            default:       eff_narrow = 1'b0;
        endcase
    end

endmodule

// File: rtl/bwc_fsm.sv
module bwc_fsm
    import bwc_pkg::*;
#(
    parameter int STR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             split,
    input  logic [STR_W-1:0] stretch,
    output logic             accept,
    output logic             beat_end,
    output logic             in_beat,
    output logic             second_beat,
    output logic             done
);

    seq_state_e        state_q, state_d;
    logic [STR_W-1:0]  cnt_q;
    logic [STR_W-1:0]  str_q;
    logic              split_q;

    always_comb begin
        accept   = (state_q == S_IDLE) && req;
        in_beat  = (state_q == S_BEAT0) || (state_q == S_BEAT1);
        beat_end = in_beat && (cnt_q == str_q);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req) state_d = S_BEAT0;
            S_BEAT0: if (beat_end) state_d = split_q ? S_BEAT1 : S_DONE;
            S_BEAT1: if (beat_end) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and per-access latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            str_q   <= '0;
            split_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                str_q   <= stretch;
                split_q <= split;
                cnt_q   <= '0;
            end else if (beat_end) begin
                cnt_q   <= '0;
            end else if (in_beat) begin
                cnt_q   <= cnt_q + STR_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        second_beat = (state_q == S_BEAT1);
        done        = (state_q == S_DONE);
    end

    AST_STRETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        in_beat |-> (cnt_q <= str_q)); // R3
    AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_beat && !beat_end) |=> (in_beat && $stable(second_beat))); // R3
    AST_DONE_FOLLOWS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(beat_end)); // R8

endmodule

// File: rtl/bwc_lanes.sv
module bwc_lanes
    import bwc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              word,
    input  logic [DATA_W-1:0] wdata,
    input  logic              narrow,
    input  logic              in_beat,
    input  logic              second_beat,
    input  logic              beat_end,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic              bus_hi_en,
    output logic              bus_lo_en,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0] a_q;
    logic              we_q, word_q, nar_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] rd_q;
    logic [ADDR_W-1:0] a_even, a_odd;
    logic [LANE_W-1:0] hi_in, lo_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q    <= '0;
            we_q   <= 1'b0;
            word_q <= 1'b0;
            nar_q  <= 1'b0;
            wd_q   <= '0;
        end else if (accept) begin
            a_q    <= addr;
            we_q   <= we;
            word_q <= word;
            nar_q  <= narrow;
            wd_q   <= wdata;
        end
    end

    always_comb begin
        a_even = {a_q[ADDR_W-1:1], 1'b0};
        a_odd  = {a_q[ADDR_W-1:1], 1'b1};
        hi_in  = bus_rdata[DATA_W-1:LANE_W];
        lo_in  = bus_rdata[LANE_W-1:0];
    end

    // Address and lane steering
    always_comb begin
        bus_addr  = '0;
        bus_hi_en = 1'b0;
        bus_lo_en = 1'b0;
        bus_wdata = '0;
        bus_we    = in_beat & we_q;
        if (in_beat) begin
            if (nar_q) begin
                bus_hi_en = 1'b1;
                if (word_q) begin
                    bus_addr  = second_beat ? a_odd : a_even;
                    bus_wdata = second_beat ? {wd_q[LANE_W-1:0], {LANE_W{1'b0}}}
                                            : {wd_q[DATA_W-1:LANE_W], {LANE_W{1'b0}}};
                end else begin
                    bus_addr  = a_q;
                    bus_wdata = {wd_q[LANE_W-1:0], {LANE_W{1'b0}}};
                end
            end else if (word_q) begin
                bus_addr  = a_even;
                bus_hi_en = 1'b1;
                bus_lo_en = 1'b1;
                bus_wdata = wd_q;
            end else if (a_q[0]) begin
                bus_addr  = a_q;
                bus_lo_en = 1'b1;
                bus_wdata = {{LANE_W{1'b0}}, wd_q[LANE_W-1:0]};
            end else begin
                bus_addr  = a_q;
                bus_hi_en = 1'b1;
                bus_wdata = {wd_q[LANE_W-1:0], {LANE_W{1'b0}}};
            end
        end
    end

    // Read assembly at the last clock of each bus cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (beat_end && !we_q) begin
            if (nar_q) begin
                if (!word_q)          rd_q <= {{LANE_W{1'b0}}, hi_in};
                else if (second_beat) rd_q[LANE_W-1:0] <= hi_in;
                else                  rd_q[DATA_W-1:LANE_W] <= hi_in;
            end else begin
                if (word_q)           rd_q <= bus_rdata;
                else if (a_q[0])      rd_q <= {{LANE_W{1'b0}}, lo_in};
                else                  rd_q <= {{LANE_W{1'b0}}, hi_in};
            end
        end
    end

    assign rdata = rd_q;

    AST_NARROW_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_beat && nar_q) |-> (bus_hi_en && !bus_lo_en)); // R5
    AST_SPLIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(second_beat) |-> (bus_addr[0] && !$past(bus_addr[0]))); // R7

endmodule

// File: rtl/bus_window_ctrl.sv
module bus_window_ctrl
    import bwc_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int REG_SPAN = 1024,
    parameter int WIN_SIZE = 1024,
    parameter int STR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic              cpu_word,
    input  logic [15:0]       cpu_wdata,
    output logic [15:0]       cpu_rdata,
    output logic              cpu_ready,
    input  logic [ADDR_W-1:0] reg_base,
    input  logic [1:0]        mode,
    input  logic              ctl_narrow,
    input  logic [STR_W-1:0]  ctl_stretch,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic              bus_hi_en,
    output logic              bus_lo_en,
    output logic [15:0]       bus_wdata,
    input  logic [15:0]       bus_rdata
);

    logic             in_win;
    logic             eff_narrow;
    logic [STR_W-1:0] eff_stretch;
    logic             accept, beat_end, in_beat, second_beat, done;

    bwc_window #(
        .ADDR_W(ADDR_W), .REG_SPAN(REG_SPAN), .WIN_SIZE(WIN_SIZE), .STR_W(STR_W)
    ) u_window (
        .addr(cpu_addr), .reg_base(reg_base), .mode(mode),
        .ctl_narrow(ctl_narrow), .ctl_stretch(ctl_stretch),
        .in_win(in_win), .eff_narrow(eff_narrow), .eff_stretch(eff_stretch)
    );

    bwc_fsm #(.STR_W(STR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req(cpu_req),
        .split(eff_narrow & cpu_word), .stretch(eff_stretch),
        .accept(accept), .beat_end(beat_end), .in_beat(in_beat),
        .second_beat(second_beat), .done(done)
    );

    bwc_lanes #(.ADDR_W(ADDR_W)) u_lanes (
        .clk(clk), .rst_n(rst_n), .accept(accept), .addr(cpu_addr),
        .we(cpu_we), .word(cpu_word), .wdata(cpu_wdata), .narrow(eff_narrow),
        .in_beat(in_beat), .second_beat(second_beat), .beat_end(beat_end),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_hi_en(bus_hi_en), .bus_lo_en(bus_lo_en), .bus_wdata(bus_wdata),
        .rdata(cpu_rdata)
    );

    assign bus_cyc   = in_beat;
    assign cpu_ready = done;

    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready); // R8
    AST_READY_AFTER_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> ($past(bus_cyc) && !bus_cyc)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |-> (!bus_hi_en && !bus_lo_en && !bus_we)); // R9
    AST_LANE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (bus_hi_en || bus_lo_en)); // R9

endmodule

// File: tb/sim_bus_window_ctrl.sv
module sim_bus_window_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_word = 1'b0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic [15:0] reg_base = '0;
    logic [1:0]  mode = 2'b01;
    logic        ctl_narrow = 1'b0;
    logic [1:0]  ctl_stretch = 2'b00;
    logic [15:0] bus_addr;
    logic        bus_cyc, bus_we, bus_hi_en, bus_lo_en;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata;
    logic        dev_narrow = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    function automatic logic [7:0] mem(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    // External device model: narrow device answers on the upper lane only
    assign bus_rdata = dev_narrow ? {mem(bus_addr), 8'hEE}
                                  : {mem({bus_addr[15:1], 1'b0}), mem({bus_addr[15:1], 1'b1})};

    bus_window_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_word(cpu_word), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .reg_base(reg_base),
        .mode(mode), .ctl_narrow(ctl_narrow), .ctl_stretch(ctl_stretch),
        .bus_addr(bus_addr), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_hi_en(bus_hi_en), .bus_lo_en(bus_lo_en), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // One access with a behavioural reference model compared every clock
    task automatic access(input logic [15:0] a, input bit w, input bit wd, input logic [15:0] dat,
                          input logic [15:0] base, input logic [1:0] md, input bit nar,
                          input logic [1:0] st, input bit perturb, input string rq);
        logic [15:0] wb;
        bit inwin, expd, enar;
        int s, beats;
        logic [15:0] ea, ewd, erd;
        bit ehi, elo;
        wb    = base + 16'd1024;
        inwin = ((a - wb) < 16'd1024);
        expd  = (md == 2'b01) || (md == 2'b10);
        s     = (expd && inwin) ? int'(st) : 0;
        enar  = (md == 2'b10) || (md == 2'b01 && inwin && nar);
        beats = (enar && wd) ? 2 : 1;
        dev_narrow = enar;
        erd = 16'h0000;
        @(negedge clk);
        cpu_addr = a; cpu_we = w; cpu_word = wd; cpu_wdata = dat;
        reg_base = base; mode = md; ctl_narrow = nar; ctl_stretch = st;
        cpu_req = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        for (int b = 0; b < beats; b++) begin
            if (enar) begin
                ehi = 1; elo = 0;
                ea  = wd ? {a[15:1], b[0]} : a;
                ewd = wd ? (b == 0 ? {dat[15:8], 8'h00} : {dat[7:0], 8'h00}) : {dat[7:0], 8'h00};
                if (wd) begin
                    if (b == 0) erd[15:8] = mem(ea); else erd[7:0] = mem(ea);
                end else erd = {8'h00, mem(ea)};
            end else if (wd) begin
                ehi = 1; elo = 1; ea = {a[15:1], 1'b0}; ewd = dat;
                erd = {mem(ea), mem({a[15:1], 1'b1})};
            end else begin
                ea = a; ehi = !a[0]; elo = a[0];
                ewd = a[0] ? {8'h00, dat[7:0]} : {dat[7:0], 8'h00};
                erd = {8'h00, mem(a)};
            end
            for (int c = 0; c <= s; c++) begin
                chk(bus_cyc === 1'b1 && cpu_ready === 1'b0 && bus_we === w,
                    {rq, " bus cycle active"}, {bus_cyc, cpu_ready, bus_we}, {1'b1, 1'b0, w});
                chk(bus_addr === ea && bus_hi_en === ehi && bus_lo_en === elo,
                    {rq, " addr/lanes"}, {bus_addr, bus_hi_en, bus_lo_en}, {ea, ehi, elo});
                if (w) chk(bus_wdata === ewd, {rq, " wdata"}, bus_wdata, ewd);
                if (perturb && b == 0 && c == 0) begin
                    // R10 R11: change every input and re-request while busy
                    cpu_addr = a ^ 16'h0402; cpu_we = !w; cpu_word = !wd; cpu_wdata = ~dat;
                    reg_base = base + 16'h0800; mode = md ^ 2'b11; ctl_narrow = !nar;
                    ctl_stretch = ~st; cpu_req = 1'b1;
                end
                @(negedge clk);
                cpu_req = 1'b0;
            end
        end
        chk(cpu_ready === 1'b1 && bus_cyc === 1'b0, {rq, " R8 ready after last cycle"},
            {cpu_ready, bus_cyc}, {1'b1, 1'b0});
        if (!w) chk(cpu_rdata === erd, {rq, " R8 read data"}, cpu_rdata, erd);
        @(negedge clk);
        chk(cpu_ready === 1'b0 && bus_cyc === 1'b0, {rq, " R8 R11 idle after ready"},
            {cpu_ready, bus_cyc}, 2'b00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cpu_ready === 0 && bus_cyc === 0 && bus_we === 0 && bus_hi_en === 0 && bus_lo_en === 0,
            "R1 reset outputs", {cpu_ready, bus_cyc, bus_we, bus_hi_en, bus_lo_en}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cpu_ready === 0 && bus_cyc === 0, "R1 idle after reset", {cpu_ready, bus_cyc}, 2'b0);

        // R3 R4 R5 R6 R7 R8: full sweep of mode, stretch, narrow bit and size
        for (int m = 0; m < 4; m++)
            for (int st = 0; st < 4; st++)
                for (int n = 0; n < 2; n++)
                    for (int wd = 0; wd < 2; wd++) begin
                        access(16'h0502, 1'b0, wd[0], 16'h0000, 16'h0000, m[1:0], n[0], st[1:0], 0,
                               "R3 R4 R6 sweep read");
                        access(16'h0604, 1'b1, wd[0], 16'hA1B2, 16'h0000, m[1:0], n[0], st[1:0], 0,
                               "R5 R7 sweep write");
                    end

        // R2: window edges at reset base
        access(16'h03FF, 1'b0, 1'b0, 16'h0, 16'h0000, 2'b01, 1'b1, 2'b11, 0, "R2 below window");
        access(16'h0400, 1'b0, 1'b1, 16'h0, 16'h0000, 2'b01, 1'b1, 2'b10, 0, "R2 window start");
        access(16'h07FF, 1'b0, 1'b0, 16'h0, 16'h0000, 2'b01, 1'b0, 2'b11, 0, "R2 window end");
        access(16'h0800, 1'b0, 1'b1, 16'h0, 16'h0000, 2'b01, 1'b1, 2'b11, 0, "R2 above window");
        // R2: relocated register block moves the window
        access(16'h0500, 1'b0, 1'b1, 16'h0, 16'h0800, 2'b01, 1'b1, 2'b11, 0, "R2 old range now outside");
        access(16'h0C00, 1'b0, 1'b1, 16'h0, 16'h0800, 2'b01, 1'b1, 2'b01, 0, "R2 relocated start");
        access(16'h0FFE, 1'b1, 1'b1, 16'h1234, 16'h0800, 2'b10, 1'b0, 2'b10, 0, "R2 relocated end");
        access(16'h1000, 1'b0, 1'b1, 16'h0, 16'h0800, 2'b01, 1'b1, 2'b11, 0, "R2 relocated above");

        // R9: wide byte lanes, even and odd
        access(16'h0640, 1'b1, 1'b0, 16'h00C3, 16'h0000, 2'b01, 1'b0, 2'b01, 0, "R9 even byte write");
        access(16'h0641, 1'b1, 1'b0, 16'h003C, 16'h0000, 2'b01, 1'b0, 2'b01, 0, "R9 odd byte write");
        access(16'h2641, 1'b0, 1'b0, 16'h0, 16'h0000, 2'b00, 1'b1, 2'b11, 0, "R9 odd byte read");

        // R10 R11: inputs change and request re-raised during an access
        access(16'h0702, 1'b0, 1'b1, 16'h0, 16'h0000, 2'b01, 1'b1, 2'b10, 1, "R10 R11 perturbed narrow read");
        access(16'h0702, 1'b1, 1'b1, 16'h5AA5, 16'h0000, 2'b10, 1'b0, 2'b00, 1, "R10 R11 perturbed write");
        access(16'h0451, 1'b0, 1'b0, 16'h0, 16'h0000, 2'b01, 1'b0, 2'b11, 1, "R10 R11 perturbed byte read");

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule